// File: doc/BRIEF.md
# Six-Stage Pipeline Interlock Controller

This block decides, every clock, which stages of a six-stage in-order instruction pipeline may advance. The stages are numbered 0 to 5: fetch, decode, address calculation, operand read, execute and write-back. The controller looks at the three back stages. From the operand-read stage it takes the valid bit, two source register tags and a memory-read flag. From the execute stage it takes the valid bit, the destination tag and a taken-branch flag. From the write-back stage it takes the valid bit, the destination tag, a memory-write flag and a slow-write flag. It returns per-stage hold, bubble and flush vectors, and it names the requester that owns the single memory port this cycle. There are no forwarding paths, so every register dependency is resolved by holding.

Fetch, operand reads and result stores share one memory port. When fetch loses the port, the fetch stage idles for one cycle. A write-back whose data arrives late (slow) leaves the pipeline and parks in a one-entry pending-write slot until `wb_done` pulses. The slot is a two-state machine. It starts in `SLOT_IDLE`. The *capture* transition (`SLOT_IDLE` to `SLOT_PEND`) fires when a slow write with a nonzero destination leaves the write-back stage, and the tag is latched. The *drain* transition (`SLOT_PEND` to `SLOT_IDLE`) fires on `wb_done`. While the slot is pending, its tag counts as an in-flight result for read-after-write checks. A later write to the same register is held in write-back, so the writes complete in program order.

A taken branch that leaves the execute stage squashes everything behind it. A flush overrides any stall raised in the same cycle.

Top module: `pipe_interlock`

## Requirements
- R1: After reset, with all valid inputs low, hold, bubble and flush are all zero, and `mem_owner` is 1 (fetch). The slot starts in `SLOT_IDLE`.
- R2: An operand-read instruction with a nonzero source tag that equals the destination of a valid execute or write-back instruction holds stages 0..3 and sets bubble bit 4. A consumer directly behind its producer stalls 2 cycles, with one unrelated instruction between them it stalls 1 cycle, and with two or more between them it does not stall.
- R3: Register 0 and invalid stages cause no hazard. A slow write to register 0 does not occupy the slot.
- R4: Port priority is store (write-back) over operand read over fetch. `mem_owner` encodes 0 none, 1 fetch, 2 operand read, 3 result store. A store or operand read that proceeds takes the port from fetch, which sets hold bit 0 and bubble bit 1 for that cycle.
- R5: When an operand read meets a store in the same cycle, the operand-read stage is held: hold = 0x0F and bubble bit 4 is set.
- R6: Hold bit i and bubble bit i refer to stage i (0 fetch to 5 write-back). A hold propagates to every earlier stage. Bubble bit i is set exactly where stage i−1 holds and stage i does not. Bubble bit 0 is always 0.
- R7: A slow write with a nonzero destination that leaves write-back takes the slot (capture). `wb_done` frees the slot at the next edge (drain). The tag stays stable while the slot is pending.
- R8: A write-back instruction whose destination equals the pending slot tag is held, together with all earlier stages (hold = 0x3F), until the slot has drained.
- R9: A slow write-back while the slot is pending is held (hold = 0x3F).
- R10: An operand-read source equal to the pending slot tag stalls the operand-read stage, including in the cycle in which `wb_done` is high.
- R11: A taken branch in execute that is not held sets flush = 0x0F, clears hold bits 0..3 and sets bubble bit 4. The flush wins over any read-after-write or port stall in the same cycle. Squashed instructions never retire, and fetch gets no port in that cycle.
- R12: A taken branch in a held execute stage raises no flush until the stage is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fo_vld | input | 1 | Operand-read stage holds an instruction |
| fo_src_a | input | REG_W | First source tag of the operand-read instruction |
| fo_src_b | input | REG_W | Second source tag of the operand-read instruction |
| fo_mem_rd | input | 1 | Operand-read instruction needs a memory read |
| ex_vld | input | 1 | Execute stage holds an instruction |
| ex_dst | input | REG_W | Destination tag in execute (0 = none) |
| ex_br_taken | input | 1 | Execute instruction is a branch that resolved taken |
| wo_vld | input | 1 | Write-back stage holds an instruction |
| wo_dst | input | REG_W | Destination tag in write-back (0 = none) |
| wo_mem_wr | input | 1 | Write-back instruction stores to memory |
| wo_slow | input | 1 | Write-back register data arrives late |
| wb_done | input | 1 | Pending slow write completes this cycle |
| hold | output | 6 | Per-stage hold, bit i = stage i |
| bubble | output | 6 | Stage i receives an empty slot at the next edge |
| flush | output | 6 | Stage i is squashed at the next edge |
| mem_owner | output | 2 | Memory port owner: 0 none, 1 fetch, 2 operand, 3 store |

## Verification
The two functions that can fall in the same cycle are the branch flush and the read-after-write or port stall on the operand-read stage. The bench provokes the collision with a program in which a producer, a taken branch and a dependent consumer follow one another, so that the consumer reaches operand read while its producer is in write-back and the branch is in execute. The flush must win: the bench counts zero operand-stage stall cycles, one flush and no retirement of the squashed consumer. An exhaustive sweep over valid bits, tags, memory flags and the branch flag compares every output vector with values computed from the priority rules.

// File: rtl/pil_pkg.sv
package pil_pkg;
    localparam int NSTG = 6;
    localparam int S_FI = 0;
    localparam int S_DI = 1;
    localparam int S_AC = 2;
    localparam int S_FO = 3;
    localparam int S_EX = 4;
    localparam int S_WR = 5;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_FETCH = 2'd1,
        PORT_OPND  = 2'd2,
        PORT_STORE = 2'd3
    } port_own_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_st_e;
endpackage

// File: rtl/pil_wb_slot.sv
module pil_wb_slot
    import pil_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wo_leave,
    input  logic             wo_slow,
    input  logic [REG_W-1:0] wo_dst,
    input  logic             wb_done,
    output logic             busy,
    output logic [REG_W-1:0] tag
);
    slot_st_e         state_q, state_d;
    logic [REG_W-1:0] tag_q;
    logic             capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture) tag_q <= wo_dst;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            SLOT_IDLE: begin
                if (wo_leave && wo_slow && (wo_dst != '0)) begin
                    capture = 1'b1;
                    state_d = SLOT_PEND;
                end
            end
            SLOT_PEND: begin
                busy = 1'b1;
                if (wb_done) state_d = SLOT_IDLE;
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    assign tag = tag_q;

    // R7: a slow nonzero write leaving write-back while idle occupies the slot
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wo_leave && wo_slow && wo_dst != '0) |=> (busy && tag == $past(wo_dst)));

    // R7: the slot keeps its tag until drained
    a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_done) |=> (busy && $stable(tag)));
endmodule

// File: rtl/pil_dep_check.sv
module pil_dep_check #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2,
    parameter int NPROD = 3
) (
    input  logic                        fo_vld,
    input  logic [NSRC-1:0][REG_W-1:0]  src,
    input  logic [NPROD-1:0]            prod_vld,
    input  logic [NPROD-1:0][REG_W-1:0] prod_tag,
    input  logic                        wo_vld,
    input  logic [REG_W-1:0]            wo_dst,
    input  logic                        wo_slow,
    input  logic                        slot_busy,
    input  logic [REG_W-1:0]            slot_tag,
    output logic                        raw_hit,
    output logic                        waw_hit,
    output logic                        slot_full
);
    logic [NSRC-1:0][NPROD-1:0] match;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar p = 0; p < NPROD; p++) begin : g_prod
            assign match[s][p] = fo_vld && (src[s] != '0) && prod_vld[p]
                                 && (prod_tag[p] == src[s]);
        end
    end

    assign raw_hit   = |match;
    assign waw_hit   = wo_vld && (wo_dst != '0) && slot_busy && (wo_dst == slot_tag);
    assign slot_full = wo_vld && wo_slow && (wo_dst != '0) && slot_busy;
endmodule

// File: rtl/pil_port_arb.sv
module pil_port_arb (
    input  logic st_req,
    input  logic st_block,
    input  logic op_req,
    input  logic op_block,
    output logic st_go,
    output logic op_conflict,
    output logic op_go,
    output logic port_taken
);
    assign st_go       = st_req && !st_block;
    assign op_conflict = op_req && st_go;
    assign op_go       = op_req && !op_block && !st_go;
    assign port_taken  = st_go || op_go;
endmodule

// File: rtl/pil_hold_chain.sv
module pil_hold_chain
    import pil_pkg::*;
(
    input  logic [NSTG-1:0] stall,
    input  logic [NSTG-1:0] kill,
    output logic [NSTG-1:0] hold,
    output logic [NSTG-1:0] bubble
);
    assign hold[NSTG-1] = stall[NSTG-1] && !kill[NSTG-1];

    for (genvar i = 0; i < NSTG - 1; i++) begin : g_up
        assign hold[i] = (stall[i] || hold[i+1]) && !kill[i];
    end

    assign bubble[0] = 1'b0;
    for (genvar i = 1; i < NSTG; i++) begin : g_bub
        assign bubble[i] = (hold[i-1] && !hold[i]) || (kill[i-1] && !kill[i]);
    end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pil_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fo_vld,
    input  logic [REG_W-1:0] fo_src_a,
    input  logic [REG_W-1:0] fo_src_b,
    input  logic             fo_mem_rd,
    input  logic             ex_vld,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_br_taken,
    input  logic             wo_vld,
    input  logic [REG_W-1:0] wo_dst,
    input  logic             wo_mem_wr,
    input  logic             wo_slow,
    input  logic             wb_done,
    output logic [NSTG-1:0]  hold,
    output logic [NSTG-1:0]  bubble,
    output logic [NSTG-1:0]  flush,
    output logic [1:0]       mem_owner
);
    localparam int NPROD = 3;
    localparam logic [NSTG-1:0] KILL_MASK = NSTG'((1 << S_EX) - 1);

    logic             slot_busy;
    logic [REG_W-1:0] slot_tag;
    logic             raw_hit, waw_hit, slot_full;
    logic             wo_stall, flush_go, fetch_go;
    logic             st_go, op_conflict, op_go, port_taken;
    logic [NSTG-1:0]  stall_vec, kill_vec;
    logic [NPROD-1:0]            prod_vld;
    logic [NPROD-1:0][REG_W-1:0] prod_tag;
    port_own_e        owner;

    assign prod_vld = {slot_busy, wo_vld, ex_vld};
    assign prod_tag = {slot_tag, wo_dst, ex_dst};

    pil_dep_check #(.REG_W(REG_W), .NSRC(2), .NPROD(NPROD)) u_dep (
        .fo_vld    (fo_vld),
        .src       ({fo_src_b, fo_src_a}),
        .prod_vld  (prod_vld),
        .prod_tag  (prod_tag),
        .wo_vld    (wo_vld),
        .wo_dst    (wo_dst),
        .wo_slow   (wo_slow),
        .slot_busy (slot_busy),
        .slot_tag  (slot_tag),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit),
        .slot_full (slot_full)
    );

    assign wo_stall = waw_hit || slot_full;
    assign flush_go = ex_vld && ex_br_taken && !wo_stall;

    pil_port_arb u_arb (
        .st_req      (wo_vld && wo_mem_wr),
        .st_block    (wo_stall),
        .op_req      (fo_vld && fo_mem_rd),
        .op_block    (raw_hit || wo_stall || flush_go),
        .st_go       (st_go),
        .op_conflict (op_conflict),
        .op_go       (op_go),
        .port_taken  (port_taken)
    );

    pil_wb_slot #(.REG_W(REG_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wo_leave (wo_vld && !wo_stall),
        .wo_slow  (wo_slow),
        .wo_dst   (wo_dst),
        .wb_done  (wb_done),
        .busy     (slot_busy),
        .tag      (slot_tag)
    );

    always_comb begin
        stall_vec       = '0;
        stall_vec[S_WR] = wo_stall;
        stall_vec[S_FO] = raw_hit || op_conflict;
        stall_vec[S_FI] = port_taken;
    end

    assign kill_vec = flush_go ? KILL_MASK : '0;

    pil_hold_chain u_chain (
        .stall  (stall_vec),
        .kill   (kill_vec),
        .hold   (hold),
        .bubble (bubble)
    );

    assign flush    = kill_vec;
    assign fetch_go = !hold[S_FI] && !flush_go;

    always_comb begin
        if (st_go)         owner = PORT_STORE;
        else if (op_go)    owner = PORT_OPND;
        else if (fetch_go) owner = PORT_FETCH;
        else               owner = PORT_NONE;
    end
    assign mem_owner = owner;

    // R4: at most one requester reaches the memory port
    a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_go, op_go, fetch_go}));

    // R2: a true dependency on the execute result stops operand read
    a_r2_raw_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_vld && fo_src_a != '0 && ex_vld && ex_dst == fo_src_a)
        |-> (hold[S_FO] || flush[S_FO]));

    // R8: a second write to the pending register waits in write-back
    a_r8_waw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wo_vld && wo_dst != '0 && slot_busy && wo_dst == slot_tag) |-> (hold == '1));

    // R11: a flush clears the holds of the squashed stages
    a_r11_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush[S_FO] |-> (hold[S_FO:S_FI] == '0 && bubble[S_EX]));

    // R12: no squash while the branch itself is held
    a_r12_no_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
        hold[S_EX] |-> (flush == '0));
endmodule

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fo_vld = 0, fo_mem_rd = 0, ex_vld = 0, ex_br_taken = 0;
    logic wo_vld = 0, wo_mem_wr = 0, wo_slow = 0, wb_done = 0;
    logic [RW-1:0] fo_src_a = 0, fo_src_b = 0, ex_dst = 0, wo_dst = 0;
    logic [5:0] hold, bubble, flush;
    logic [1:0] mem_owner;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pipe_interlock #(.REG_W(RW)) u_pipe_interlock (
        .clk(clk), .rst_n(rst_n),
        .fo_vld(fo_vld), .fo_src_a(fo_src_a), .fo_src_b(fo_src_b), .fo_mem_rd(fo_mem_rd),
        .ex_vld(ex_vld), .ex_dst(ex_dst), .ex_br_taken(ex_br_taken),
        .wo_vld(wo_vld), .wo_dst(wo_dst), .wo_mem_wr(wo_mem_wr), .wo_slow(wo_slow),
        .wb_done(wb_done),
        .hold(hold), .bubble(bubble), .flush(flush), .mem_owner(mem_owner)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic zero_in();
        fo_vld = 0; fo_mem_rd = 0; ex_vld = 0; ex_br_taken = 0;
        wo_vld = 0; wo_mem_wr = 0; wo_slow = 0; wb_done = 0;
        fo_src_a = 0; fo_src_b = 0; ex_dst = 0; wo_dst = 0;
    endtask

    // program store for the pipeline environment
    int p_dst[16], p_sa[16], p_sb[16], p_tgt[16];
    bit p_rd[16], p_wr[16], p_br[16];
    int plen;
    int c_h3, c_fonly, c_own2, c_own3, c_flush, c_ret;
    bit ret_seen[16];

    task automatic clr_prog();
        for (int i = 0; i < 16; i++) begin
            p_dst[i] = 0; p_sa[i] = 0; p_sb[i] = 0; p_tgt[i] = 0;
            p_rd[i] = 0; p_wr[i] = 0; p_br[i] = 0;
        end
        plen = 0;
    endtask

    task automatic add_ins(int dst, int sa, int sb, bit rd, bit wr, bit br, int tgt);
        p_dst[plen] = dst; p_sa[plen] = sa; p_sb[plen] = sb;
        p_rd[plen] = rd; p_wr[plen] = wr; p_br[plen] = br; p_tgt[plen] = tgt;
        plen++;
    endtask

    task automatic run_prog();
        bit sv[6], nv[6];
        int sid[6], nid[6];
        int fp = 0;
        c_h3 = 0; c_fonly = 0; c_own2 = 0; c_own3 = 0; c_flush = 0; c_ret = 0;
        for (int i = 0; i < 16; i++) ret_seen[i] = 0;
        for (int i = 0; i < 6; i++) begin sv[i] = 0; sid[i] = 0; end
        for (int cyc = 0; cyc < 80; cyc++) begin
            @(negedge clk);
            fo_vld = sv[3];
            fo_src_a = sv[3] ? RW'(p_sa[sid[3]]) : '0;
            fo_src_b = sv[3] ? RW'(p_sb[sid[3]]) : '0;
            fo_mem_rd = sv[3] && p_rd[sid[3]];
            ex_vld = sv[4];
            ex_dst = sv[4] ? RW'(p_dst[sid[4]]) : '0;
            ex_br_taken = sv[4] && p_br[sid[4]];
            wo_vld = sv[5];
            wo_dst = sv[5] ? RW'(p_dst[sid[5]]) : '0;
            wo_mem_wr = sv[5] && p_wr[sid[5]];
            wo_slow = 0; wb_done = 0;
            #2;
            if (hold[3] && !flush[3]) c_h3++;
            if (hold[0] && !hold[1]) c_fonly++;
            if (mem_owner == 2'd2) c_own2++;
            if (mem_owner == 2'd3) c_own3++;
            if (flush[0]) c_flush++;
            if (sv[5] && !hold[5]) begin c_ret++; ret_seen[sid[5]] = 1; end
            for (int i = 5; i >= 0; i--) begin
                nv[i] = sv[i]; nid[i] = sid[i];
                if (flush[i]) nv[i] = 0;
                else if (hold[i]) ;
                else if (i == 0) begin
                    if (fp < plen) begin nv[0] = 1; nid[0] = fp; fp++; end
                    else nv[0] = 0;
                end
                else if (bubble[i]) nv[i] = 0;
                else begin nv[i] = sv[i-1]; nid[i] = sid[i-1]; end
            end
            if (flush[0]) fp = p_tgt[sid[4]];
            for (int i = 0; i < 6; i++) begin sv[i] = nv[i]; sid[i] = nid[i]; end
            if (fp >= plen && !(sv[0] | sv[1] | sv[2] | sv[3] | sv[4] | sv[5])) break;
        end
        @(negedge clk);
        zero_in();
    endtask

    function automatic int sweep_exp(bit v3, bit v4, bit v5, int d4, int d5, int sa,
                                     bit rd, bit wr, bit br);
        bit fl, wop, raw, st3, fop, h0;
        int h, b, f, o;
        fl  = br && v4;
        wop = v5 && wr;
        raw = v3 && sa != 0 && ((v4 && d4 == sa) || (v5 && d5 == sa));
        if (fl) begin
            h = 0; b = 16; f = 15; o = wop ? 3 : 0;
        end else begin
            st3 = raw || (v3 && rd && wop);
            fop = v3 && rd && !st3;
            h0  = st3 || wop || fop;
            h = st3 ? 15 : (h0 ? 1 : 0);
            b = st3 ? 16 : (h0 ? 2 : 0);
            f = 0;
            o = wop ? 3 : (fop ? 2 : (h0 ? 0 : 1));
        end
        return (o << 18) | (f << 12) | (b << 6) | h;
    endfunction

    function automatic int dut_vec();
        return int'({mem_owner, flush, bubble, hold});
    endfunction

    task automatic step_check(string tag, int exp_hold, int exp_flush);
        #2;
        chk({tag, " hold"}, int'(hold), exp_hold);
        chk({tag, " flush"}, int'(flush), exp_flush);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        zero_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #2;
        chk("R1 reset vector", dut_vec(), (1 << 18));

        // exhaustive sweep with the slot idle: R2 R3 R4 R5 R6 R11
        for (int v = 0; v < 8; v++)
        for (int d4 = 0; d4 < 3; d4++)
        for (int d5 = 0; d5 < 3; d5++)
        for (int sa = 0; sa < 3; sa++)
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            zero_in();
            fo_vld = v[0]; ex_vld = v[1]; wo_vld = v[2];
            ex_dst = RW'(d4); wo_dst = RW'(d5); fo_src_a = RW'(sa);
            fo_mem_rd = m[0]; wo_mem_wr = m[1]; ex_br_taken = m[2];
            #2;
            chk("R2/R3/R4/R5/R6/R11 sweep", dut_vec(),
                sweep_exp(v[0], v[1], v[2], d4, d5, sa, m[0], m[1], m[2]));
        end
        @(negedge clk); zero_in();

        // slot and ordering: R7 R8 R9 R10 R12 R11 R3
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 4; wo_slow = 1;
        step_check("R7 capture cycle", 0, 0);
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 4; ex_vld = 1; ex_br_taken = 1;
        step_check("R8/R12 waw with branch", 63, 0);
        @(negedge clk); wb_done = 1;
        step_check("R8 waw during drain", 63, 0);
        @(negedge clk); wb_done = 0;
        step_check("R7/R11 drained then flush", 0, 15);
        chk("R11 bubble after flush", int'(bubble), 16);
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 6; wo_slow = 1;
        step_check("R7 capture tag 6", 0, 0);
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 7; wo_slow = 1;
        step_check("R9 slot full", 63, 0);
        @(negedge clk); zero_in(); fo_vld = 1; fo_src_b = 6;
        step_check("R10 raw on slot tag", 15, 0);
        chk("R10 bubble", int'(bubble), 16);
        @(negedge clk); wb_done = 1;
        step_check("R10 raw during drain", 15, 0);
        @(negedge clk); wb_done = 0;
        step_check("R10 raw released", 0, 0);
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 0; wo_slow = 1;
        step_check("R3 slow write to r0", 0, 0);
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 5; wo_slow = 1;
        step_check("R3 slot untouched by r0", 0, 0);
        @(negedge clk); zero_in(); wo_vld = 1; wo_dst = 5;
        step_check("R8 waw tag 5", 63, 0);
        @(negedge clk); wb_done = 1;
        #2;
        @(negedge clk); zero_in();
        step_check("R7 drained idle", 0, 0);

        // R2 stall count versus distance between producer and consumer
        for (int g = 0; g < 4; g++) begin
            clr_prog();
            add_ins(3, 0, 0, 0, 0, 0, 0);
            for (int k = 0; k < g; k++) add_ins(8 + k, 0, 0, 0, 0, 0, 0);
            add_ins(9, 3, 0, 0, 0, 0, 0);
            run_prog();
            chk($sformatf("R2 stall cycles gap %0d", g), c_h3, (g < 2) ? 2 - g : 0);
            chk("R2 all retired", c_ret, plen);
        end
        clr_prog();
        add_ins(3, 0, 0, 0, 0, 0, 0); add_ins(9, 1, 3, 0, 0, 0, 0);
        run_prog();
        chk("R2 second source stall cycles", c_h3, 2);
        clr_prog();
        add_ins(0, 0, 0, 0, 0, 0, 0); add_ins(9, 0, 0, 0, 0, 0, 0);
        run_prog();
        chk("R3 r0 producer no stall", c_h3, 0);

        // R4 each operand read costs fetch one cycle
        clr_prog();
        for (int i = 0; i < 6; i++) add_ins(10 + i, 0, 0, (i == 1 || i == 2 || i == 4), 0, 0, 0);
        run_prog();
        chk("R4 fetch stall cycles", c_fonly, 3);
        chk("R4 operand port cycles", c_own2, 3);
        chk("R4 no operand stall", c_h3, 0);

        // R5 store and read two apart collide once
        clr_prog();
        add_ins(10, 0, 0, 0, 1, 0, 0); add_ins(11, 0, 0, 0, 0, 0, 0); add_ins(12, 0, 0, 1, 0, 0, 0);
        run_prog();
        chk("R5 conflict stall cycles", c_h3, 1);
        chk("R5 store port cycles", c_own3, 1);
        chk("R5 operand port cycles", c_own2, 1);
        chk("R4 fetch-only stalls after conflict", c_fonly, 1);
        clr_prog();
        add_ins(10, 0, 0, 0, 1, 0, 0); add_ins(12, 0, 0, 1, 0, 0, 0);
        run_prog();
        chk("R4 adjacent store/read stalls", c_fonly, 2);
        chk("R5 adjacent no conflict", c_h3, 0);

        // R11 taken branch squashes the younger instructions
        clr_prog();
        for (int i = 0; i < 10; i++) add_ins(10 + i, 0, 0, 0, 0, (i == 2), 6);
        run_prog();
        chk("R11 flush count", c_flush, 1);
        chk("R11 retired count", c_ret, 7);
        chk("R11 squashed retired", int'(ret_seen[3]) + int'(ret_seen[4]) + int'(ret_seen[5]), 0);
        chk("R11 target retired", int'(ret_seen[6]), 1);

        // R11 flush and RAW stall in the same cycle: flush wins
        clr_prog();
        add_ins(3, 0, 0, 0, 0, 0, 0); add_ins(0, 0, 0, 0, 0, 1, 5);
        add_ins(9, 3, 0, 0, 0, 0, 0); add_ins(11, 0, 0, 0, 0, 0, 0);
        add_ins(12, 0, 0, 0, 0, 0, 0); add_ins(13, 0, 0, 0, 0, 0, 0);
        run_prog();
        chk("R11 flush over raw stall cycles", c_h3, 0);
        chk("R11 flush over raw count", c_flush, 1);
        chk("R11 squashed consumer", int'(ret_seen[2]), 0);
        chk("R11 retired after collision", c_ret, 3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule